// File: doc/BRIEF.md
# BCD Real-Time Calendar Register File

This block keeps wall-clock time and a calendar in binary-coded decimal and presents them to software as eight byte-wide registers on a small address/data port. A one-cycle pulse from an external one-hertz prescaler advances the seconds. The seconds carry into the minutes, the minutes into the hours, and the hours into both the day of the week and the day of the month. The day of the month rolls into the month, and the month rolls into the year. The date limit follows the length of the current month, and February has 29 days in years divisible by four.

The layout is fixed. Offset 0 is the control byte: calibration magnitude in bits 4..0, the calibration sign in bit 5, a read-freeze bit in bit 6 and a write-hold bit in bit 7. Offsets 1 to 7 hold seconds, minutes, hours, weekday, date, month and year. The oscillator halt flag sits in bit 7 of the seconds register, and the frequency-test flag sits in bit 6 of the weekday register. Setting the read-freeze bit gives software a stable copy of the time to read while counting carries on. The write-hold bit lets software stage a complete new time, which is committed in one step when the bit is cleared. The calibration fields and the halt flag are driven out to the prescaler.

Top module: `rtc_calendar_regs`

## Requirements
- R1: After reset the registers read: control 0x00, seconds 0x80 (halt flag set, 00 s), minutes 0x00, hours 0x00, weekday 0x01, date 0x01, month 0x01, year 0x00, and osc_halt is 1.
- R2: A tick with the halt flag at 0 and the write-hold bit at 0 advances seconds by one in BCD. Seconds 59 wraps to 00 and increments minutes. Minutes 59 wraps to 00 and increments hours. Hours 23 wraps to 00.
- R3: When hours wrap, the weekday increments and wraps from 7 to 1.
- R4: When hours wrap, the date increments. After the last day of the month (31; 30 for months 04, 06, 09, 11; 28 for month 02, or 29 when the binary value of the year is divisible by 4) the date becomes 01 and the month increments.
- R5: Month 12 wraps to 01 and increments the year. Year 99 wraps to 00.
- R6: Bit 7 written to offset 1 sets or clears the halt flag at once, whatever the write-hold bit is. While the flag is 1, ticks are ignored. osc_halt mirrors the flag.
- R7: While control bit 6 is 1, reads of offsets 1..7 return the time as it stood when the bit was set, and the counters keep running. Once the bit is cleared, reads return the live time.
- R8: Setting control bit 7 captures the live time into a staging copy and suspends counting. Writes to offsets 1..7 then update only the staging copy, and reads still show the counters. Clearing bit 7 loads the whole staging copy into the counters, so any field that was not written keeps its captured value. While bit 7 is 0, the time fields of offsets 1..7 ignore writes.
- R9: A tick in the same cycle as the control write that sets bit 7, or that clears it, is dropped. The next tick after the release advances from the loaded value.
- R10: Must-be-zero bits are ignored on write and read as 0: seconds none besides the halt flag, minutes bit 7, hours bits 7..6, weekday bits 7 and 5..3, date bits 7..6, month bits 7..5. Weekday bit 6 is a stored read/write flag.
- R11: The control byte reads back as written. cal_trim drives control bits 4..0 and cal_faster drives bit 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1hz | input | 1 | One-cycle advance pulse from the prescaler |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | Write when 1, read when 0 |
| bus_addr | input | 3 | Register offset 0..7 |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| osc_halt | output | 1 | Halt flag to the prescaler |
| cal_trim | output | 5 | Calibration magnitude |
| cal_faster | output | 1 | Calibration sign, 1 = speed up |

## Verification
Two events can land in the same cycle here: a prescaler tick and the control write that opens or closes the write-hold window. The bench raises tick_1hz in the very cycle of each of those two control writes. It judges the outcome by reading the seconds back. After the opening write, seconds must equal the value before the write. After the closing write, seconds must equal the staged value exactly, and only a later tick may move it by one.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
   localparam int NUM_FIELDS = 7;
   localparam int FLD_SEC   = 0;
   localparam int FLD_MIN   = 1;
   localparam int FLD_HOUR  = 2;
   localparam int FLD_WDAY  = 3;
   localparam int FLD_DATE  = 4;
   localparam int FLD_MONTH = 5;
   localparam int FLD_YEAR  = 6;

   localparam logic [2:0] OFS_CTRL = 3'd0;
   localparam logic [2:0] OFS_SEC  = 3'd1;
   localparam logic [2:0] OFS_WDAY = 3'd4;

   localparam int CTL_SIGN_BIT  = 5;
   localparam int CTL_FREEZE_BIT = 6;
   localparam int CTL_HOLD_BIT  = 7;

   function automatic logic [7:0] fld_min(input int i);
      case (i)
         FLD_WDAY, FLD_DATE, FLD_MONTH: return 8'h01;
         default:                       return 8'h00;
      endcase
   endfunction

   function automatic logic [7:0] fld_max(input int i);
      case (i)
         FLD_SEC, FLD_MIN: return 8'h59;
         FLD_HOUR:         return 8'h23;
         FLD_WDAY:         return 8'h07;
         FLD_DATE:         return 8'h31;
         FLD_MONTH:        return 8'h12;
         default:          return 8'h99;
      endcase
   endfunction

   function automatic logic [7:0] fld_mask(input int i);
      case (i)
         FLD_SEC, FLD_MIN:   return 8'h7F;
         FLD_HOUR, FLD_DATE: return 8'h3F;
         FLD_WDAY:           return 8'h07;
         FLD_MONTH:          return 8'h1F;
         default:            return 8'hFF;
      endcase
   endfunction

   function automatic logic [7:0] bcd_inc(input logic [7:0] v);
      if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
      return {v[7:4], v[3:0] + 4'd1};
   endfunction

   function automatic logic [6:0] bcd_to_bin(input logic [7:0] v);
      return 7'(v[7:4]) * 7'd10 + 7'(v[3:0]);
   endfunction

   function automatic logic [7:0] month_last_day(input logic [7:0] mon, input logic [7:0] yr);
      logic [6:0] yb;
      yb = bcd_to_bin(yr);
      case (mon)
         8'h02:                      return (yb[1:0] == 2'b00) ? 8'h29 : 8'h28;
         8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
         default:                    return 8'h31;
      endcase
   endfunction
endpackage

// File: rtl/rtc_bcd_counter.sv
module rtc_bcd_counter #(
   parameter logic [7:0] MIN_VAL = 8'h00,
   parameter logic [7:0] RST_VAL = 8'h00
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       step,
   input  logic       load,
   input  logic [7:0] load_val,
   input  logic [7:0] limit,
   output logic [7:0] value,
   output logic       wrap
);
   logic [7:0] next_val;

   assign wrap     = step && (value >= limit);
   assign next_val = wrap ? MIN_VAL : rtc_pkg::bcd_inc(value);

   always_ff @(posedge clk) begin
      if (!rst_n)     value <= RST_VAL;
      else if (load)  value <= load_val;
      else if (step)  value <= next_val;
   end
endmodule

// File: rtl/rtc_time_chain.sv
module rtc_time_chain #(
   parameter int NF = rtc_pkg::NUM_FIELDS
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            run,
   input  logic            load,
   input  logic [NF*8-1:0] load_bus,
   output logic [NF*8-1:0] live_bus
);
   import rtc_pkg::*;

   logic [NF-1:0] wrap;
   logic [NF-1:0] step;
   logic [7:0]    val   [NF];
   logic [7:0]    limit [NF];

   generate
      if (NF != NUM_FIELDS) begin : g_bad_nf
         $error("rtc_time_chain: NF must equal the calendar field count");
      end
      for (genvar g = 0; g < NF; g++) begin : g_fld
         if (g == FLD_SEC) begin : g_src
            assign step[g] = run;
         end else if (g == FLD_WDAY || g == FLD_DATE) begin : g_src
            assign step[g] = wrap[FLD_HOUR];
         end else if (g == FLD_MONTH) begin : g_src
            assign step[g] = wrap[FLD_DATE];
         end else begin : g_src
            assign step[g] = wrap[g-1];
         end

         if (g == FLD_DATE) begin : g_lim
            assign limit[g] = month_last_day(val[FLD_MONTH], val[FLD_YEAR]);
         end else begin : g_lim
            assign limit[g] = fld_max(g);
         end

         rtc_bcd_counter #(
            .MIN_VAL(fld_min(g)),
            .RST_VAL(fld_min(g))
         ) i_ctr (
            .clk      (clk),
            .rst_n    (rst_n),
            .step     (step[g]),
            .load     (load),
            .load_val (load_bus[g*8 +: 8]),
            .limit    (limit[g]),
            .value    (val[g]),
            .wrap     (wrap[g])
         );
         assign live_bus[g*8 +: 8] = val[g];
      end
   endgenerate

   AST_SEC_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !load && val[FLD_SEC] == 8'h59 && val[FLD_MIN] != 8'h59)
      |=> (val[FLD_SEC] == 8'h00 && val[FLD_MIN] == bcd_inc($past(val[FLD_MIN]))));  // R2
   AST_WDAY_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && step[FLD_WDAY] && val[FLD_WDAY] == 8'h07) |=> (val[FLD_WDAY] == 8'h01));  // R3
   AST_YEAR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && step[FLD_YEAR] && val[FLD_YEAR] == 8'h99) |=> (val[FLD_YEAR] == 8'h00));  // R5
endmodule

// File: rtl/rtc_host_port.sv
module rtc_host_port #(
   parameter int   NF            = rtc_pkg::NUM_FIELDS,
   parameter int   CAL_W         = 5,
   parameter logic RESET_STOPPED = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            tick,
   input  logic            bus_sel,
   input  logic            bus_we,
   input  logic [2:0]      bus_addr,
   input  logic [7:0]      bus_wdata,
   input  logic [NF*8-1:0] live_bus,
   output logic            run,
   output logic            load,
   output logic [NF*8-1:0] stage_bus,
   output logic [7:0]      rdata,
   output logic            osc_halt,
   output logic [CAL_W-1:0] cal_trim,
   output logic            cal_faster
);
   import rtc_pkg::*;

   localparam logic [7:0] CAL_MASK  = 8'((1 << CAL_W) - 1);
   localparam logic [7:0] CTRL_MASK = 8'hE0 | CAL_MASK;

   logic [7:0] ctrl_q;
   logic       halt_q, ftest_q;
   logic       hold_q, freeze_q;
   logic       ctrl_wr, hold_set, any_wr;
   logic [7:0] live_f  [NF];
   logic [7:0] stage_q [NF];
   logic [7:0] snap_q  [NF];
   logic [2:0] idx;
   logic [7:0] view;

   assign hold_q   = ctrl_q[CTL_HOLD_BIT];
   assign freeze_q = ctrl_q[CTL_FREEZE_BIT];
   assign any_wr   = bus_sel && bus_we;
   assign ctrl_wr  = any_wr && (bus_addr == OFS_CTRL);
   assign hold_set = ctrl_wr && bus_wdata[CTL_HOLD_BIT] && !hold_q;
   assign load     = ctrl_wr && !bus_wdata[CTL_HOLD_BIT] && hold_q;
   assign run      = tick && !halt_q && !hold_q && !(ctrl_wr && bus_wdata[CTL_HOLD_BIT]);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q  <= '0;
         halt_q  <= RESET_STOPPED;
         ftest_q <= 1'b0;
      end else begin
         if (ctrl_wr) ctrl_q <= bus_wdata & CTRL_MASK;
         if (any_wr && bus_addr == OFS_SEC)  halt_q  <= bus_wdata[7];
         if (any_wr && bus_addr == OFS_WDAY) ftest_q <= bus_wdata[6];
      end
   end

   generate
      if (CAL_W < 1 || CAL_W > 5) begin : g_bad_cal
         $error("rtc_host_port: CAL_W must lie in 1..5");
      end
      for (genvar g = 0; g < NF; g++) begin : g_fld
         localparam logic [2:0] OFS = 3'(g + 1);
         assign live_f[g] = live_bus[g*8 +: 8];
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               stage_q[g] <= fld_min(g);
               snap_q[g]  <= fld_min(g);
            end else begin
               if (hold_set)
                  stage_q[g] <= live_f[g];
               else if (hold_q && any_wr && bus_addr == OFS)
                  stage_q[g] <= bus_wdata & fld_mask(g);
               if (!freeze_q) snap_q[g] <= live_f[g];
            end
         end
         assign stage_bus[g*8 +: 8] = stage_q[g];
      end
   endgenerate

   assign idx  = bus_addr - 3'd1;
   assign view = freeze_q ? snap_q[idx] : live_f[idx];

   always_comb begin
      if (bus_addr == OFS_CTRL) begin
         rdata = ctrl_q;
      end else begin
         rdata = view & fld_mask(int'(idx));
         if (bus_addr == OFS_SEC)  rdata[7] = halt_q;
         if (bus_addr == OFS_WDAY) rdata[6] = ftest_q;
      end
   end

   assign osc_halt   = halt_q;
   assign cal_trim   = ctrl_q[CAL_W-1:0];
   assign cal_faster = ctrl_q[CTL_SIGN_BIT];

   AST_HOURS_MBZ: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == 3'd3) |-> (rdata[7:6] == 2'b00));  // R10
   AST_HOLD_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_q && !load) |=> $stable(live_bus));  // R8
endmodule

// File: rtl/rtc_calendar_regs.sv
module rtc_calendar_regs #(
   parameter int   DATA_W        = 8,
   parameter int   CAL_W         = 5,
   parameter logic RESET_STOPPED = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_1hz,
   input  logic             bus_sel,
   input  logic             bus_we,
   input  logic [2:0]       bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic             osc_halt,
   output logic [CAL_W-1:0] cal_trim,
   output logic             cal_faster
);
   localparam int NF = rtc_pkg::NUM_FIELDS;

   logic            run, load;
   logic [NF*8-1:0] live_bus, stage_bus;

   generate
      if (DATA_W != 8) begin : g_bad_width
         $error("rtc_calendar_regs: register layout requires DATA_W == 8");
      end
   endgenerate

   rtc_host_port #(
      .NF(NF), .CAL_W(CAL_W), .RESET_STOPPED(RESET_STOPPED)
   ) i_host (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (tick_1hz),
      .bus_sel    (bus_sel),
      .bus_we     (bus_we),
      .bus_addr   (bus_addr),
      .bus_wdata  (bus_wdata),
      .live_bus   (live_bus),
      .run        (run),
      .load       (load),
      .stage_bus  (stage_bus),
      .rdata      (bus_rdata),
      .osc_halt   (osc_halt),
      .cal_trim   (cal_trim),
      .cal_faster (cal_faster)
   );

   rtc_time_chain #(.NF(NF)) i_chain (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run),
      .load     (load),
      .load_bus (stage_bus),
      .live_bus (live_bus)
   );

   AST_LOAD_COMMITS: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (live_bus == $past(stage_bus)));  // R8
   AST_HALT_STILL: assert property (@(posedge clk) disable iff (!rst_n)
      (osc_halt && !load) |=> $stable(live_bus[7:0]));  // R6
endmodule

// File: tb/test_rtc_calendar_regs.sv
module test_rtc_calendar_regs;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_1hz = 1'b0;
   logic       bus_sel = 1'b0, bus_we = 1'b0;
   logic [2:0] bus_addr = 3'd0;
   logic [7:0] bus_wdata = 8'h00;
   logic [7:0] bus_rdata;
   logic       osc_halt;
   logic [4:0] cal_trim;
   logic       cal_faster;

   int errors = 0;
   int checks = 0;

   always #10 clk = ~clk;

   rtc_calendar_regs i_rtc_calendar_regs (
      .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz),
      .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .osc_halt(osc_halt), .cal_trim(cal_trim), .cal_faster(cal_faster)
   );

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d, input logic with_tick);
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d; tick_1hz = with_tick;
      @(negedge clk);
      bus_sel = 1'b0; bus_we = 1'b0; tick_1hz = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
      #2 d = bus_rdata;
      @(negedge clk);
      bus_sel = 1'b0;
   endtask

   task automatic tick_once();
      @(negedge clk);
      tick_1hz = 1'b1;
      @(negedge clk);
      tick_1hz = 1'b0;
   endtask

   function automatic logic [7:0] to_bcd(input int n);
      return 8'(((n / 10) << 4) | (n % 10));
   endfunction

   function automatic int from_bcd(input logic [7:0] v);
      return int'(v[7:4]) * 10 + int'(v[3:0]);
   endfunction

   function automatic int days_of(input int m, input int y);
      if (m == 2) return (y % 4 == 0) ? 29 : 28;
      if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
      return 31;
   endfunction

   task automatic set_time(input int s, input int mi, input int h, input int wd,
                           input int dt, input int mo, input int y);
      wr(3'd0, 8'h80, 1'b0);
      wr(3'd1, to_bcd(s), 1'b0);
      wr(3'd2, to_bcd(mi), 1'b0);
      wr(3'd3, to_bcd(h), 1'b0);
      wr(3'd4, to_bcd(wd), 1'b0);
      wr(3'd5, to_bcd(dt), 1'b0);
      wr(3'd6, to_bcd(mo), 1'b0);
      wr(3'd7, to_bcd(y), 1'b0);
      wr(3'd0, 8'h00, 1'b0);
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin : main
      logic [7:0] v, base;
      logic [7:0] exp_rst [8];
      exp_rst = '{8'h00, 8'h80, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00};
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset contents
      for (int a = 0; a < 8; a++) begin
         rd(3'(a), v);
         check("R1 reset register", v, exp_rst[a]);
      end
      check("R1 osc_halt at reset", {7'd0, osc_halt}, 8'h01);

      // R6 halted clock ignores ticks
      tick_once(); tick_once();
      rd(3'd1, v); check("R6 ticks ignored while halted", v, 8'h80);
      // R6 / R8 clear halt; seconds field ignored while hold bit is 0
      wr(3'd1, 8'h15, 1'b0);
      check("R6 osc_halt cleared", {7'd0, osc_halt}, 8'h00);
      rd(3'd1, v); check("R8 time field ignored when not held", v, 8'h00);
      wr(3'd2, 8'h33, 1'b0);
      rd(3'd2, v); check("R8 minutes ignored when not held", v, 8'h00);

      // R2 sweep of 3661 ticks from midnight
      for (int n = 1; n <= 3661; n++) begin
         tick_once();
         rd(3'd1, v); check("R2 seconds", v, to_bcd(n % 60));
         rd(3'd2, v); check("R2 minutes", v, to_bcd((n / 60) % 60));
         rd(3'd3, v); check("R2 hours", v, to_bcd(n / 3600));
      end

      // R3 R4 R5 end-of-month sweep over four years
      foreach (exp_rst[k]) begin end
      for (int yi = 0; yi < 4; yi++) begin
         int y;
         y = (yi == 0) ? 23 : (yi == 1) ? 24 : (yi == 2) ? 0 : 99;
         for (int m = 1; m <= 12; m++) begin
            int last;
            last = days_of(m, y);
            set_time(59, 59, 23, 6, last - 1, m, y);
            tick_once();
            rd(3'd5, v); check("R4 date before month end", v, to_bcd(last));
            rd(3'd4, v); check("R3 weekday increments", v, 8'h07);
            set_time(59, 59, 23, 7, last, m, y);
            tick_once();
            rd(3'd3, v); check("R2 hours 23 wraps", v, 8'h00);
            rd(3'd4, v); check("R3 weekday 7 wraps to 1", v, 8'h01);
            rd(3'd5, v); check("R4 date wraps to 01", v, 8'h01);
            rd(3'd6, v); check("R5 month advance", v, to_bcd(m == 12 ? 1 : m + 1));
            rd(3'd7, v); check("R5 year advance", v, to_bcd(m == 12 ? (y + 1) % 100 : y));
         end
      end

      // R7 read freeze
      set_time(10, 20, 5, 2, 14, 3, 24);
      wr(3'd0, 8'h40, 1'b0);
      tick_once(); tick_once(); tick_once();
      rd(3'd1, v); check("R7 frozen seconds", v, 8'h10);
      rd(3'd2, v); check("R7 frozen minutes", v, 8'h20);
      wr(3'd0, 8'h00, 1'b0);
      rd(3'd1, v); check("R7 live after unfreeze", v, 8'h13);

      // R8 R9 hold window with coincident ticks
      rd(3'd1, base);
      wr(3'd0, 8'h80, 1'b1);
      rd(3'd1, v); check("R9 tick dropped on hold set", v, base);
      wr(3'd1, 8'h30, 1'b0);
      rd(3'd1, v); check("R8 staged write not visible", v, base);
      tick_once();
      rd(3'd1, v); check("R8 tick ignored in hold", v, base);
      wr(3'd0, 8'h00, 1'b1);
      rd(3'd1, v); check("R9 tick dropped on release", v, 8'h30);
      rd(3'd2, v); check("R8 unwritten minutes kept", v, 8'h20);
      rd(3'd5, v); check("R8 unwritten date kept", v, 8'h14);
      tick_once();
      rd(3'd1, v); check("R9 counting resumes", v, 8'h31);

      // R10 must-be-zero bits and test flag
      wr(3'd0, 8'h80, 1'b0);
      wr(3'd2, 8'h85, 1'b0);
      wr(3'd3, 8'hC7, 1'b0);
      wr(3'd4, 8'hBB, 1'b0);
      wr(3'd5, 8'hD2, 1'b0);
      wr(3'd6, 8'hE9, 1'b0);
      wr(3'd0, 8'h00, 1'b0);
      rd(3'd2, v); check("R10 minutes bit7 zero", v, 8'h05);
      rd(3'd3, v); check("R10 hours bits 7..6 zero", v, 8'h07);
      rd(3'd4, v); check("R10 weekday masked", v, 8'h03);
      rd(3'd5, v); check("R10 date bits 7..6 zero", v, 8'h12);
      rd(3'd6, v); check("R10 month bits 7..5 zero", v, 8'h09);
      wr(3'd4, 8'h43, 1'b0);
      rd(3'd4, v); check("R10 test flag stored", v, 8'h43);
      wr(3'd4, 8'h03, 1'b0);
      rd(3'd4, v); check("R10 test flag cleared", v, 8'h03);

      // R6 halt set mid-run
      wr(3'd1, 8'h80, 1'b0);
      rd(3'd1, base);
      tick_once();
      rd(3'd1, v); check("R6 halt freezes seconds", v, base);
      wr(3'd1, 8'h00, 1'b0);

      // R11 calibration byte, all sign/magnitude codes
      for (int c = 0; c < 64; c++) begin
         wr(3'd0, 8'(c), 1'b0);
         rd(3'd0, v); check("R11 control readback", v, 8'(c));
         check("R11 cal_trim", {3'd0, cal_trim}, 8'(c & 31));
         check("R11 cal_faster", {7'd0, cal_faster}, 8'(c >> 5));
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule